// File: doc/BRIEF.md
# VCC Supply and Fault Hiccup Supervisor

This block sequences the supply of an off-line switching controller whose VCC rail is refilled from the high-voltage bus by a switched startup current source. It receives already-synchronized comparator flags that tell where VCC sits relative to six thresholds. It also receives three fault flags: an external latch-request pin, an over-temperature flag and a feedback-above-regulation flag. From these it decides when the startup source is on and at which strength, when the gate drive may switch, and when the soft-start ramp must be relaunched.

In normal operation the source regulates VCC between the minimum and turn-on thresholds while the drive runs. A brief undervoltage dip only pauses the drive. Any lasting fault starts a two-round discharge/recharge sequence. The drive restarts, together with a soft-start pulse, only on the second arrival at the turn-on level, and only if no fault remains. A latched fault keeps the supervisor cycling with the drive off until VCC falls below the logic-reset level. A build option chooses whether a sustained overload latches or retries. All persistence windows are parameters counted in clock cycles.

Top module: `vcc_fault_supervisor`

## Requirements
- R1: After reset the drive is off, no soft-start pulse is given, and the startup source is requested.
- R2: While the source is requested, `hv_trickle_en` is high when VCC is below the inhibit threshold and `hv_full_en` is high when VCC is above it. The two are never high together.
- R3: From the power-up state, the clock edge that samples `vcc_gt_on` high starts the drive. `ss_restart` is then high for exactly one cycle and the source is released.
- R4: While running, the source turns off at the edge that samples `vcc_gt_on` high. It turns on at the edge that samples `vcc_gt_min` low, and holds its state in between.
- R5: `drv_en` goes low in the same cycle that `vcc_gt_uvlo` is low, with no clock edge needed.
- R6: If `vcc_gt_uvlo` returns high before UVLO_FILT_CYC consecutive low samples, the drive resumes one edge later without a soft-start pulse.
- R7: If `vcc_gt_uvlo` is sampled low UVLO_FILT_CYC times in a row, the next edge enters the hiccup sequence and the source turns off.
- R8: In hiccup the drive is off. The source is off until `vcc_gt_hiccup` is sampled low, then on until `vcc_gt_on` is sampled high. The first arrival at turn-on only starts another discharge. The second arrival restarts the drive with a one-cycle `ss_restart`.
- R9: If `thermal_hot` is high at a restart arrival, the sequence keeps cycling with the drive off. The next arrival without the fault restarts.
- R10: `fb_over_limit` sampled high OVLD_CYC times in a row while running enters hiccup at the next edge, and a shorter burst has no effect. With LATCH_ON_OVLD=0 the supervisor restarts after the double hiccup; with LATCH_ON_OVLD=1 it stays off.
- R11: `ext_latch_hi` sampled high LATCH_FILT_CYC times in a row latches the supervisor off in either option, and a shorter burst has no effect.
- R12: `thermal_hot` sampled high THERM_FILT_CYC times in a row while running enters hiccup at the next edge, and a shorter burst has no effect.
- R13: The edge that samples `vcc_gt_reset` low clears any latch and returns to the power-up state. The next arrival at turn-on starts the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vcc_gt_inhibit | input | 1 | VCC above the inhibit threshold |
| vcc_gt_reset | input | 1 | VCC above the logic-reset threshold |
| vcc_gt_hiccup | input | 1 | VCC above the hiccup threshold |
| vcc_gt_uvlo | input | 1 | VCC above the undervoltage threshold |
| vcc_gt_min | input | 1 | VCC above the minimum operating threshold |
| vcc_gt_on | input | 1 | VCC at or above the turn-on threshold |
| ext_latch_hi | input | 1 | External latch-request pin above its threshold |
| thermal_hot | input | 1 | Over-temperature flag |
| fb_over_limit | input | 1 | Feedback above the regulation limit |
| hv_full_en | output | 1 | Full-strength startup current enable |
| hv_trickle_en | output | 1 | Low-current (inhibit) startup source select |
| drv_en | output | 1 | Gate drive enable |
| ss_restart | output | 1 | One-cycle soft-start relaunch pulse |

## Verification
The properties assume the six VCC flags are nested: a flag for a higher threshold is never high while a flag for a lower one is low. They also assume each flag is stable across a clock edge. The bench enforces both conditions by driving VCC as a single level index from which all six flags are derived, and by changing inputs one time unit after the rising edge. The fault flags are driven as bursts of a chosen length, one shorter and one exactly at each window. The level index then walks the discharge/recharge rounds so that every arrival at turn-on can be observed.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RUN    = 3'd1,
    ST_UVWAIT = 3'd2,
    ST_HICDIS = 3'd3,
    ST_HICCHG = 3'd4
  } sup_state_e;

  typedef struct packed {
    logic on;
    logic min;
    logic uvlo;
    logic hiccup;
    logic reset;
    logic inhibit;
  } vcc_flags_t;

  localparam int unsigned NUM_FILT = 4;
  localparam int unsigned CH_UVLO  = 0;
  localparam int unsigned CH_LATCH = 1;
  localparam int unsigned CH_THERM = 2;
  localparam int unsigned CH_OVLD  = 3;

endpackage

// File: rtl/sup_persist.sv
module sup_persist #(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic held
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || !din)  cnt <= '0;
    else if (cnt != LIM)   cnt <= cnt + 1'b1;
  end

  assign held = (cnt == LIM);
endmodule

// File: rtl/sup_hiccup_fsm.sv
module sup_hiccup_fsm
  import sup_pkg::*;
#(
  parameter bit LATCH_ON_OVLD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  vcc_flags_t vf,
  input  logic       thermal_now,
  input  logic       uvlo_held,
  input  logic       latch_held,
  input  logic       therm_held,
  input  logic       ovld_held,
  output logic       in_run,
  output logic       run_like,
  output logic       src_on,
  output logic       ss_pulse
);
  sup_state_e st;
  logic       latched;
  logic       second_round;
  logic       ovld_latches;

  generate
    if (LATCH_ON_OVLD) begin : g_ovld_latch
      assign ovld_latches = 1'b1;
    end else begin : g_ovld_retry
      assign ovld_latches = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_OFF;
      src_on       <= 1'b1;
      latched      <= 1'b0;
      second_round <= 1'b0;
      ss_pulse     <= 1'b0;
    end else begin
      ss_pulse <= 1'b0;
      if (!vf.reset) begin
        st           <= ST_OFF;
        src_on       <= 1'b1;
        latched      <= 1'b0;
        second_round <= 1'b0;
      end else begin
        if (latch_held) latched <= 1'b1;
        unique case (st)
          ST_OFF: begin
            src_on <= 1'b1;
            if (vf.on) begin
              src_on <= 1'b0;
              if (latched || latch_held || thermal_now) begin
                st           <= ST_HICDIS;
                second_round <= 1'b1;
              end else begin
                st       <= ST_RUN;
                ss_pulse <= 1'b1;
              end
            end
          end
          ST_RUN, ST_UVWAIT: begin
            if (vf.on)        src_on <= 1'b0;
            else if (!vf.min) src_on <= 1'b1;
            if (latch_held) begin
              st <= ST_HICDIS; src_on <= 1'b0; second_round <= 1'b0;
            end else if (st == ST_RUN && ovld_held) begin
              if (ovld_latches) latched <= 1'b1;
              st <= ST_HICDIS; src_on <= 1'b0; second_round <= 1'b0;
            end else if (st == ST_RUN && therm_held) begin
              st <= ST_HICDIS; src_on <= 1'b0; second_round <= 1'b0;
            end else if (st == ST_RUN && !vf.uvlo) begin
              st <= ST_UVWAIT;
            end else if (st == ST_UVWAIT && vf.uvlo) begin
              st <= ST_RUN;
            end else if (st == ST_UVWAIT && uvlo_held) begin
              st <= ST_HICDIS; src_on <= 1'b0; second_round <= 1'b0;
            end
          end
          ST_HICDIS: begin
            src_on <= 1'b0;
            if (!vf.hiccup) begin
              st     <= ST_HICCHG;
              src_on <= 1'b1;
            end
          end
          ST_HICCHG: begin
            src_on <= 1'b1;
            if (vf.on) begin
              src_on <= 1'b0;
              if (!second_round) begin
                second_round <= 1'b1;
                st           <= ST_HICDIS;
              end else if (latched || latch_held || thermal_now) begin
                st <= ST_HICDIS;
              end else begin
                st           <= ST_RUN;
                ss_pulse     <= 1'b1;
                second_round <= 1'b0;
              end
            end
          end
          default: st <= ST_OFF;
        endcase
      end
    end
  end

  assign in_run   = (st == ST_RUN);
  assign run_like = (st == ST_RUN) || (st == ST_UVWAIT);
endmodule

// File: rtl/sup_outstage.sv
module sup_outstage (
  input  logic in_run,
  input  logic src_on,
  input  logic gt_uvlo,
  input  logic gt_inhibit,
  input  logic ss_q,
  output logic hv_full_en,
  output logic hv_trickle_en,
  output logic drv_en,
  output logic ss_restart
);
  assign drv_en        = in_run & gt_uvlo;
  assign hv_full_en    = src_on & gt_inhibit;
  assign hv_trickle_en = src_on & ~gt_inhibit;
  assign ss_restart    = ss_q;
endmodule

// File: rtl/vcc_fault_supervisor.sv
module vcc_fault_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned UVLO_FILT_CYC  = 500,
  parameter int unsigned LATCH_FILT_CYC = 500,
  parameter int unsigned THERM_FILT_CYC = 750,
  parameter int unsigned OVLD_CYC       = 1180000,
  parameter bit          LATCH_ON_OVLD  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_gt_inhibit,
  input  logic vcc_gt_reset,
  input  logic vcc_gt_hiccup,
  input  logic vcc_gt_uvlo,
  input  logic vcc_gt_min,
  input  logic vcc_gt_on,
  input  logic ext_latch_hi,
  input  logic thermal_hot,
  input  logic fb_over_limit,
  output logic hv_full_en,
  output logic hv_trickle_en,
  output logic drv_en,
  output logic ss_restart
);
  localparam int unsigned HOLD_TAB [NUM_FILT] =
    '{UVLO_FILT_CYC, LATCH_FILT_CYC, THERM_FILT_CYC, OVLD_CYC};

  vcc_flags_t vf;
  logic [NUM_FILT-1:0] f_din, f_clr, f_held;
  logic in_run, run_like, src_on, ss_q;

  assign vf = '{on: vcc_gt_on, min: vcc_gt_min, uvlo: vcc_gt_uvlo,
                hiccup: vcc_gt_hiccup, reset: vcc_gt_reset,
                inhibit: vcc_gt_inhibit};

  assign f_din[CH_UVLO]  = ~vcc_gt_uvlo;
  assign f_clr[CH_UVLO]  = ~run_like;
  assign f_din[CH_LATCH] = ext_latch_hi;
  assign f_clr[CH_LATCH] = ~vcc_gt_reset;
  assign f_din[CH_THERM] = thermal_hot;
  assign f_clr[CH_THERM] = 1'b0;
  assign f_din[CH_OVLD]  = fb_over_limit;
  assign f_clr[CH_OVLD]  = ~in_run;

  generate
    for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
      sup_persist #(.HOLD_CYC(HOLD_TAB[i])) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (f_clr[i]),
        .din  (f_din[i]),
        .held (f_held[i])
      );
    end
  endgenerate

  sup_hiccup_fsm #(.LATCH_ON_OVLD(LATCH_ON_OVLD)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .vf         (vf),
    .thermal_now(thermal_hot),
    .uvlo_held  (f_held[CH_UVLO]),
    .latch_held (f_held[CH_LATCH]),
    .therm_held (f_held[CH_THERM]),
    .ovld_held  (f_held[CH_OVLD]),
    .in_run     (in_run),
    .run_like   (run_like),
    .src_on     (src_on),
    .ss_pulse   (ss_q)
  );

  sup_outstage u_out (
    .in_run       (in_run),
    .src_on       (src_on),
    .gt_uvlo      (vcc_gt_uvlo),
    .gt_inhibit   (vcc_gt_inhibit),
    .ss_q         (ss_q),
    .hv_full_en   (hv_full_en),
    .hv_trickle_en(hv_trickle_en),
    .drv_en       (drv_en),
    .ss_restart   (ss_restart)
  );
endmodule

// File: rtl/vcc_fault_supervisor_chk.sv
module vcc_fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic vcc_gt_inhibit,
  input logic vcc_gt_reset,
  input logic vcc_gt_uvlo,
  input logic vcc_gt_on,
  input logic hv_full_en,
  input logic hv_trickle_en,
  input logic drv_en,
  input logic ss_restart
);
  assert_src_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_full_en && hv_trickle_en));

  assert_full_needs_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hv_full_en |-> vcc_gt_inhibit);

  assert_ss_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  assert_ss_with_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_restart && vcc_gt_uvlo) |-> drv_en);

  assert_dss_off_at_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && $past(drv_en) && $past(vcc_gt_on)) |-> (!hv_full_en && !hv_trickle_en));

  assert_uvlo_kills_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_gt_uvlo |-> !drv_en);

  assert_ss_after_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_restart) |-> $past(vcc_gt_on));

  assert_logic_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_gt_reset |=> !drv_en);
endmodule

bind vcc_fault_supervisor vcc_fault_supervisor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vcc_gt_inhibit(vcc_gt_inhibit),
  .vcc_gt_reset  (vcc_gt_reset),
  .vcc_gt_uvlo   (vcc_gt_uvlo),
  .vcc_gt_on     (vcc_gt_on),
  .hv_full_en    (hv_full_en),
  .hv_trickle_en (hv_trickle_en),
  .drv_en        (drv_en),
  .ss_restart    (ss_restart)
);

// File: tb/vcc_fault_supervisor_tb.sv
module vcc_fault_supervisor_tb;
  localparam int UV = 4, LT = 3, TH = 5, OV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic g_inh, g_rst, g_hic, g_uv, g_min, g_on;
  logic ext = 1'b0, hot = 1'b0, fbo = 1'b0;
  logic a_full, a_trk, a_drv, a_ss;
  logic l_full, l_trk, l_drv, l_ss;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  vcc_fault_supervisor #(.UVLO_FILT_CYC(UV), .LATCH_FILT_CYC(LT), .THERM_FILT_CYC(TH),
                         .OVLD_CYC(OV), .LATCH_ON_OVLD(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .vcc_gt_inhibit(g_inh), .vcc_gt_reset(g_rst),
    .vcc_gt_hiccup(g_hic), .vcc_gt_uvlo(g_uv), .vcc_gt_min(g_min), .vcc_gt_on(g_on),
    .ext_latch_hi(ext), .thermal_hot(hot), .fb_over_limit(fbo),
    .hv_full_en(a_full), .hv_trickle_en(a_trk), .drv_en(a_drv), .ss_restart(a_ss));

  vcc_fault_supervisor #(.UVLO_FILT_CYC(UV), .LATCH_FILT_CYC(LT), .THERM_FILT_CYC(TH),
                         .OVLD_CYC(OV), .LATCH_ON_OVLD(1'b1)) u_dut_lat (
    .clk(clk), .rst_n(rst_n), .vcc_gt_inhibit(g_inh), .vcc_gt_reset(g_rst),
    .vcc_gt_hiccup(g_hic), .vcc_gt_uvlo(g_uv), .vcc_gt_min(g_min), .vcc_gt_on(g_on),
    .ext_latch_hi(ext), .thermal_hot(hot), .fb_over_limit(fbo),
    .hv_full_en(l_full), .hv_trickle_en(l_trk), .drv_en(l_drv), .ss_restart(l_ss));

  // VCC level index: 0 below inhibit ... 6 at/above turn-on; flags stay nested
  task automatic lvl(input int l);
    g_inh = (l >= 1); g_rst = (l >= 2); g_hic = (l >= 3);
    g_uv  = (l >= 4); g_min = (l >= 5); g_on  = (l >= 6);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // vector order {drv_en, hv_full_en, hv_trickle_en, ss_restart}
  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic both(input string req, input logic [3:0] expv);
    chk({req, " retry"}, {a_drv, a_full, a_trk, a_ss}, expv);
    chk({req, " latch"}, {l_drv, l_full, l_trk, l_ss}, expv);
  endtask

  // one discharge to below hiccup, then recharge to turn-on
  task automatic round(input string req, input logic [3:0] exp_dis, input logic [3:0] exp_on);
    lvl(2); tick(); both(req, exp_dis);
    lvl(6); tick(); both(req, exp_on);
  endtask

  initial begin
    lvl(0);
    tick(3);
    rst_n = 1'b1;
    #1;
    both("R1", 4'b0010);

    // R2: sweep of levels in the power-up state
    for (int l = 0; l <= 5; l++) begin
      lvl(l); tick();
      both("R2", {1'b0, (l >= 1) ? 1'b1 : 1'b0, (l == 0) ? 1'b1 : 1'b0, 1'b0});
    end

    lvl(6); tick(); both("R3 start", 4'b1001);
    tick(); both("R3 pulse ends", 4'b1000);

    // R4 self-supply hysteresis
    lvl(5); tick(); both("R4 between", 4'b1000);
    lvl(4); tick(); both("R4 below min", 4'b1100);
    lvl(5); tick(); both("R4 hold on", 4'b1100);
    lvl(6); tick(); both("R4 off at on", 4'b1000);

    // R5/R6 short dip
    lvl(3); #1; both("R5 immediate", 4'b0000);
    tick(); both("R6 waiting", 4'b0100);
    tick();
    lvl(4); #1; both("R6 not yet", 4'b0100);
    tick(); both("R6 resumed", 4'b1100);
    lvl(6); tick(); both("R6 settle", 4'b1000);

    // R7 lasting dip
    lvl(3); tick(UV); both("R7 window", 4'b0100);
    tick(); both("R7 hiccup", 4'b0000);
    tick(); both("R8 discharging", 4'b0000);
    lvl(2); tick(); both("R8 charging", 4'b0100);
    lvl(5); tick(); both("R8 charging", 4'b0100);
    lvl(6); tick(); both("R8 first arrival", 4'b0000);
    round("R8 second arrival", 4'b0100, 4'b1001);
    tick(); both("R8 running", 4'b1000);

    // R12 thermal
    hot = 1'b1; tick(TH - 1); hot = 1'b0; tick(); both("R12 short ignored", 4'b1000);
    hot = 1'b1; tick(TH); both("R12 window", 4'b1000);
    tick(); both("R12 hiccup", 4'b0000);
    round("R9 first", 4'b0100, 4'b0000);
    round("R9 fault present", 4'b0100, 4'b0000);
    hot = 1'b0;
    round("R9 cleared restart", 4'b0100, 4'b1001);
    tick();

    // R10 overload
    fbo = 1'b1; tick(OV - 1); fbo = 1'b0; tick(); both("R10 short ignored", 4'b1000);
    fbo = 1'b1; tick(OV); both("R10 window", 4'b1000);
    tick(); both("R10 hiccup", 4'b0000);
    fbo = 1'b0;
    round("R10 first", 4'b0100, 4'b0000);
    lvl(2); tick(); both("R10 charge", 4'b0100);
    lvl(6); tick();
    chk("R10 retry option restarts", {a_drv, a_full, a_trk, a_ss}, 4'b1001);
    chk("R10 latch option stays off", {l_drv, l_full, l_trk, l_ss}, 4'b0000);
    tick();

    // R11 external latch
    ext = 1'b1; tick(LT - 1); ext = 1'b0; tick();
    chk("R11 short ignored", {a_drv, a_full, a_trk, a_ss}, 4'b1000);
    ext = 1'b1; tick(LT);
    chk("R11 window", {a_drv, a_full, a_trk, a_ss}, 4'b1000);
    tick(); both("R11 latched off", 4'b0000);
    ext = 1'b0;
    for (int k = 0; k < 4; k++) round("R11 stays off", 4'b0100, 4'b0000);

    // R13 logic reset
    lvl(1); tick(); both("R13 cleared", 4'b0100);
    lvl(5); tick(); both("R13 charging", 4'b0100);
    lvl(6); tick(); both("R13 restart", 4'b1001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule